// File: doc/BRIEF.md
# Predicated Vector Compare-and-Branch Evaluator

This block decides whether a vector branch is taken. After a start pulse it walks a vector of element pairs, one pair per clock cycle, compares each pair with the selected relation, and writes each outcome as one bit of a result mask. A source mask chooses which elements take part. After the last element, a separate decision cycle turns the collected outcomes into a single taken or not-taken flag. The flag means either "every counted test passed" or "every counted test failed", as chosen by the result-inversion control.

The unit reads operands through an index output. Each cycle it shows the number of the element it is evaluating on `elem_idx`, and the surrounding datapath returns that element's two operands in the same cycle. The predicate masks, their control flags and the vector length are decoded upstream and are sampled when `start` is accepted. With fail-on-first enabled, the walk ends at the first active element whose comparison fails, and the shortened length is reported on `trunc_len`.

Top module: `vcmp_branch_unit`

## Requirements
- R1: `cmp_op` selects the relation applied to each active element. The encodings are 0 equal, 1 not equal, 2 signed less-than, 3 signed greater-or-equal, 4 unsigned less-than and 5 unsigned greater-or-equal. Codes 6 and 7 always fail. A pass writes 1 into result bit i and a failure writes 0.
- R2: Element i is active when `src_mask[i] ^ src_inv` is 1. Only active elements are compared.
- R3: With `zeroing` set, an inactive element writes 0 into its result bit and counts as a failed test.
- R4: With `zeroing` clear, an inactive element keeps the value its result bit received from `res_init`, and it does not count in the branch decision.
- R5: With the effective inversion at 0, `branch_taken` is 1 only when at least one test counted and every counted test passed.
- R6: With `res_present` and `res_inv` both set, `branch_taken` is 1 only when at least one test counted and every counted test failed.
- R7: With `res_present` clear, no result bit is written, so `res_mask` keeps the value `res_init` gave it. The inversion is then treated as 0 whatever `res_inv` holds.
- R8: Without fail-on-first, all elements are evaluated and `trunc_len` equals the vector length. A `vec_len` above MAX_LEN is clamped to MAX_LEN. `done` rises L+1 clock edges after the edge that accepts `start`, where L is the number of elements evaluated.
- R9: With `ffirst` set, evaluation stops at the first active element j whose comparison fails. That element's result bit is written, `trunc_len` is j, and bits above j keep their `res_init` values.
- R10: `done` is high for exactly one cycle. `res_mask`, `branch_taken` and `trunc_len` hold still until the next accepted `start`. A length of zero gives `done` with `branch_taken` at 0 and `trunc_len` at 0.
- R11: A `start` pulse that arrives while `busy` is high is ignored. The run in progress finishes with its original settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins a run when the unit is idle |
| vec_len | input | LEN_W | Number of elements, sampled on start |
| cmp_op | input | 3 | Comparison selector, sampled on start |
| src_mask | input | MAX_LEN | Element-enable mask, sampled on start |
| src_inv | input | 1 | Inverts the element-enable mask |
| zeroing | input | 1 | Inactive elements write 0 and count as failed |
| ffirst | input | 1 | Stop at the first failing active element |
| res_present | input | 1 | A result mask is associated and written |
| res_inv | input | 1 | Branch on all-fail instead of all-pass |
| res_init | input | MAX_LEN | Prior contents of the result mask, loaded on start |
| elem_idx | output | IDX_W | Element whose operands are requested this cycle |
| elem_a | input | ELEM_W | First operand of element `elem_idx` |
| elem_b | input | ELEM_W | Second operand of element `elem_idx` |
| res_mask | output | MAX_LEN | Result mask |
| branch_taken | output | 1 | Branch decision, valid from `done` onward |
| done | output | 1 | One-cycle completion pulse |
| trunc_len | output | LEN_W | Number of elements before the stopping point |
| busy | output | 1 | A run is in progress |

## Verification
The hardest case to reach is a fail-on-first stop that lands on an element behind masked-out ones. To check it, the bench must see at once that the bits past the stop still hold their prior values, that zeroed bits before the stop were cleared, and that the decision counted only the tested prefix. Pseudo-random runs cover this case. They mix masks, inversions, zeroing and small operand ranges, which makes equal and failing pairs frequent. The bench also runs an exhaustive sweep of every relation over every operand pair at a narrow element width. A further run pulses `start` in the middle of a vector, with a different length and opcode on the inputs.

// File: rtl/vcb_pkg.sv
package vcb_pkg;

   typedef enum logic [2:0] {
      CMP_EQ  = 3'd0,
      CMP_NE  = 3'd1,
      CMP_LT  = 3'd2,
      CMP_GE  = 3'd3,
      CMP_LTU = 3'd4,
      CMP_GEU = 3'd5
   } vcb_cmp_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_RUN    = 2'd1,
      ST_DECIDE = 2'd2
   } vcb_state_e;

   typedef struct packed {
      logic       src_inv;
      logic       zeroing;
      logic       ffirst;
      logic       res_present;
      logic       res_inv;
      logic [2:0] op;
   } vcb_cfg_t;

endpackage

// File: rtl/vcb_elem_cmp.sv
module vcb_elem_cmp
   import vcb_pkg::*;
#(
   parameter int ELEM_W     = 32,
   parameter bit SHARED_SUB = 1'b1
) (
   input  logic [ELEM_W-1:0] a,
   input  logic [ELEM_W-1:0] b,
   input  logic [2:0]        op,
   output logic              pass
);

   localparam int MSB = ELEM_W - 1;

   generate
      if (ELEM_W < 2) begin : g_bad_width
         $error("vcb_elem_cmp: ELEM_W must be at least 2");
      end
   endgenerate

   logic eq;
   logic lt_s;
   logic lt_u;

   assign eq = (a == b);

   generate
      if (SHARED_SUB) begin : g_sub
         logic [ELEM_W:0] diff;
         assign diff = {1'b0, a} - {1'b0, b};
         assign lt_u = diff[ELEM_W];
         assign lt_s = (a[MSB] != b[MSB]) ? a[MSB] : lt_u;
      end else begin : g_direct
         assign lt_u = (a < b);
         assign lt_s = ($signed(a) < $signed(b));
      end
   endgenerate

   always_comb begin
      case (op)
         CMP_EQ:  pass = eq;
         CMP_NE:  pass = ~eq;
         CMP_LT:  pass = lt_s;
         CMP_GE:  pass = ~lt_s;
         CMP_LTU: pass = lt_u;
         CMP_GEU: pass = ~lt_u;
         default: pass = 1'b0;
      endcase
   end

endmodule

// File: rtl/vcb_seq.sv
module vcb_seq
   import vcb_pkg::*;
#(
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = $clog2(MAX_LEN + 1),
   parameter int IDX_W   = $clog2(MAX_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len_in,
   input  logic             stop_req,
   output logic             load,
   output logic             proc,
   output logic             decide,
   output logic             busy,
   output logic [IDX_W-1:0] idx,
   output logic [LEN_W-1:0] len_lat,
   output logic [LEN_W-1:0] trunc_q
);

   localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_LEN);

   vcb_state_e       st_q;
   logic [LEN_W-1:0] len_clamped;
   logic             at_last;

   assign len_clamped = (len_in > LEN_CAP) ? LEN_CAP : len_in;
   assign load        = start && (st_q == ST_IDLE);
   assign proc        = (st_q == ST_RUN);
   assign decide      = (st_q == ST_DECIDE);
   assign busy        = (st_q != ST_IDLE);
   assign at_last     = (LEN_W'(idx) == (len_lat - 1'b1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         idx     <= '0;
         len_lat <= '0;
         trunc_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (start) begin
                  len_lat <= len_clamped;
                  trunc_q <= len_clamped;
                  idx     <= '0;
                  st_q    <= (len_clamped == '0) ? ST_DECIDE : ST_RUN;
               end
            end
            ST_RUN: begin
               if (stop_req) begin
                  trunc_q <= LEN_W'(idx);
                  st_q    <= ST_DECIDE;
               end else if (at_last) begin
                  st_q    <= ST_DECIDE;
               end else begin
                  idx     <= idx + 1'b1;
               end
            end
            default: begin
               st_q <= ST_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/vcb_mask_reg.sv
module vcb_mask_reg #(
   parameter int MAX_LEN = 64,
   parameter int IDX_W   = $clog2(MAX_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [MAX_LEN-1:0] init,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic               wr_val,
   output logic [MAX_LEN-1:0] q
);

   generate
      for (genvar i = 0; i < MAX_LEN; i++) begin : g_bit
         logic bit_q;
         logic hit;
         assign hit = wr_en && (wr_idx == IDX_W'(i));
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               bit_q <= 1'b0;
            end else if (load) begin
               bit_q <= init[i];
            end else if (hit) begin
               bit_q <= wr_val;
            end
         end
         assign q[i] = bit_q;
      end
   endgenerate

endmodule

// File: rtl/vcb_verdict.sv
module vcb_verdict (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic upd,
   input  logic pass_bit,
   input  logic decide,
   input  logic inv_eff,
   output logic taken
);

   logic any_q;
   logic allp_q;
   logic allf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         any_q  <= 1'b0;
         allp_q <= 1'b1;
         allf_q <= 1'b1;
         taken  <= 1'b0;
      end else if (clear) begin
         any_q  <= 1'b0;
         allp_q <= 1'b1;
         allf_q <= 1'b1;
         taken  <= 1'b0;
      end else begin
         if (upd) begin
            any_q  <= 1'b1;
            allp_q <= allp_q & pass_bit;
            allf_q <= allf_q & ~pass_bit;
         end
         if (decide) begin
            taken <= any_q & (inv_eff ? allf_q : allp_q);
         end
      end
   end

endmodule

// File: rtl/vcmp_branch_unit.sv
module vcmp_branch_unit
   import vcb_pkg::*;
#(
   parameter int ELEM_W     = 32,
   parameter int MAX_LEN    = 64,
   parameter bit SHARED_SUB = 1'b1,
   localparam int LEN_W     = $clog2(MAX_LEN + 1),
   localparam int IDX_W     = $clog2(MAX_LEN)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [LEN_W-1:0]   vec_len,
   input  logic [2:0]         cmp_op,
   input  logic [MAX_LEN-1:0] src_mask,
   input  logic               src_inv,
   input  logic               zeroing,
   input  logic               ffirst,
   input  logic               res_present,
   input  logic               res_inv,
   input  logic [MAX_LEN-1:0] res_init,
   output logic [IDX_W-1:0]   elem_idx,
   input  logic [ELEM_W-1:0]  elem_a,
   input  logic [ELEM_W-1:0]  elem_b,
   output logic [MAX_LEN-1:0] res_mask,
   output logic               branch_taken,
   output logic               done,
   output logic [LEN_W-1:0]   trunc_len,
   output logic               busy
);

   generate
      if (MAX_LEN < 2) begin : g_bad_len
         $error("vcmp_branch_unit: MAX_LEN must be at least 2");
      end
   endgenerate

   vcb_cfg_t           cfg_q;
   logic [MAX_LEN-1:0] src_mask_q;
   logic               load;
   logic               proc;
   logic               decide;
   logic [LEN_W-1:0]   len_lat;
   logic               active;
   logic               pass;
   logic               counted;
   logic               stop_req;
   logic               wr_en;
   logic               inv_eff;
   logic               done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q      <= '0;
         src_mask_q <= '0;
      end else if (load) begin
         cfg_q.src_inv     <= src_inv;
         cfg_q.zeroing     <= zeroing;
         cfg_q.ffirst      <= ffirst;
         cfg_q.res_present <= res_present;
         cfg_q.res_inv     <= res_inv;
         cfg_q.op          <= cmp_op;
         src_mask_q        <= src_mask;
      end
   end

   vcb_seq #(
      .MAX_LEN (MAX_LEN),
      .LEN_W   (LEN_W),
      .IDX_W   (IDX_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .len_in   (vec_len),
      .stop_req (stop_req),
      .load     (load),
      .proc     (proc),
      .decide   (decide),
      .busy     (busy),
      .idx      (elem_idx),
      .len_lat  (len_lat),
      .trunc_q  (trunc_len)
   );

   vcb_elem_cmp #(
      .ELEM_W     (ELEM_W),
      .SHARED_SUB (SHARED_SUB)
   ) u_cmp (
      .a    (elem_a),
      .b    (elem_b),
      .op   (cfg_q.op),
      .pass (pass)
   );

   assign active   = src_mask_q[elem_idx] ^ cfg_q.src_inv;
   assign counted  = proc && (active || cfg_q.zeroing);
   assign stop_req = proc && cfg_q.ffirst && active && !pass;
   assign wr_en    = counted && cfg_q.res_present;
   assign inv_eff  = cfg_q.res_present && cfg_q.res_inv;

   vcb_mask_reg #(
      .MAX_LEN (MAX_LEN),
      .IDX_W   (IDX_W)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (load),
      .init   (res_init),
      .wr_en  (wr_en),
      .wr_idx (elem_idx),
      .wr_val (active && pass),
      .q      (res_mask)
   );

   vcb_verdict u_verdict (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (load),
      .upd      (counted),
      .pass_bit (active && pass),
      .decide   (decide),
      .inv_eff  (inv_eff),
      .taken    (branch_taken)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else begin
         done_q <= decide;
      end
   end

   assign done = done_q;

endmodule

// File: rtl/vcb_checker.sv
module vcb_checker #(
   parameter int MAX_LEN = 64,
   parameter int LEN_W   = 7
) (
   input logic               clk,
   input logic               rst_n,
   input logic               start,
   input logic               busy,
   input logic               done,
   input logic               branch_taken,
   input logic [MAX_LEN-1:0] res_mask,
   input logic [LEN_W-1:0]   trunc_len,
   input logic [LEN_W-1:0]   len_lat,
   input logic               ff_lat
);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> ($stable(res_mask) && $stable(branch_taken) && $stable(trunc_len))); // R10

   AST_EMPTY_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (len_lat == '0)) |-> !branch_taken); // R10

   AST_TRUNC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (trunc_len <= len_lat)); // R9

   AST_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !ff_lat) |-> (trunc_len == len_lat)); // R8

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(len_lat)); // R11

endmodule

bind vcmp_branch_unit vcb_checker #(
   .MAX_LEN (MAX_LEN),
   .LEN_W   (LEN_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .start        (start),
   .busy         (busy),
   .done         (done),
   .branch_taken (branch_taken),
   .res_mask     (res_mask),
   .trunc_len    (trunc_len),
   .len_lat      (len_lat),
   .ff_lat       (cfg_q.ffirst)
);

// File: tb/sim_vcmp_branch_unit.sv
module sim_vcmp_branch_unit;

   localparam int EW = 4;
   localparam int ML = 8;
   localparam int LW = 4;
   localparam int IW = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [LW-1:0] vec_len = '0;
   logic [2:0]    cmp_op = '0;
   logic [ML-1:0] src_mask = '0;
   logic          src_inv = 1'b0;
   logic          zeroing = 1'b0;
   logic          ffirst = 1'b0;
   logic          res_present = 1'b0;
   logic          res_inv = 1'b0;
   logic [ML-1:0] res_init = '0;
   logic [IW-1:0] elem_idx;
   logic [EW-1:0] elem_a;
   logic [EW-1:0] elem_b;
   logic [ML-1:0] res_mask;
   logic          branch_taken;
   logic          done;
   logic [LW-1:0] trunc_len;
   logic          busy;

   logic [EW-1:0] a_arr [ML];
   logic [EW-1:0] b_arr [ML];

   int  n_checks = 0;
   int  n_fail   = 0;
   int  cyc      = 0;
   bit  finished = 1'b0;
   logic [31:0] rs = 32'h1234_5678;

   assign elem_a = a_arr[elem_idx];
   assign elem_b = b_arr[elem_idx];

   always #10 clk = ~clk;

   vcmp_branch_unit #(.ELEM_W(EW), .MAX_LEN(ML)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .vec_len(vec_len), .cmp_op(cmp_op),
      .src_mask(src_mask), .src_inv(src_inv), .zeroing(zeroing), .ffirst(ffirst),
      .res_present(res_present), .res_inv(res_inv), .res_init(res_init),
      .elem_idx(elem_idx), .elem_a(elem_a), .elem_b(elem_b), .res_mask(res_mask),
      .branch_taken(branch_taken), .done(done), .trunc_len(trunc_len), .busy(busy)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [31:0] nxt();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return rs;
   endfunction

   function automatic bit ref_cmp(input logic [2:0] op, input logic [EW-1:0] a, input logic [EW-1:0] b);
      case (op)
         3'd0: return a == b;
         3'd1: return a != b;
         3'd2: return $signed(a) < $signed(b);
         3'd3: return !($signed(a) < $signed(b));
         3'd4: return a < b;
         3'd5: return !(a < b);
         default: return 1'b0;
      endcase
   endfunction

   // glitch_at: nonzero -> pulse start (with other len/op) at that wait count (R11)
   task automatic run_vec(input int len, input logic [2:0] op, input logic [ML-1:0] sm,
                          input bit sinv, input bit zer, input bit ff, input bit rp,
                          input bit rinv, input logic [ML-1:0] init, input int glitch_at);
      logic [ML-1:0] e_mask;
      int  eff_len, e_trunc, e_proc, cnt;
      bit  any, allp, allf, e_taken, act, p;
      logic [ML-1:0] hold_mask;
      logic hold_taken;
      logic [LW-1:0] hold_trunc;
      eff_len = (len > ML) ? ML : len;
      e_mask = init; any = 0; allp = 1; allf = 1;
      e_trunc = eff_len; e_proc = eff_len;
      for (int i = 0; i < eff_len; i++) begin
         act = sm[i] ^ sinv;
         if (act) begin
            p = ref_cmp(op, a_arr[i], b_arr[i]);
            if (rp) e_mask[i] = p;
            any = 1; allp = allp & p; allf = allf & !p;
            if (ff && !p) begin
               e_trunc = i; e_proc = i + 1;
               break;
            end
         end else if (zer) begin
            if (rp) e_mask[i] = 1'b0;
            any = 1; allp = 0;
         end
      end
      e_taken = any && ((rp && rinv) ? allf : allp);

      @(negedge clk);
      vec_len = LW'(len); cmp_op = op; src_mask = sm; src_inv = sinv; zeroing = zer;
      ffirst = ff; res_present = rp; res_inv = rinv; res_init = init; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cnt = 1;
      while (!done && cnt < 40) begin
         if (glitch_at != 0 && cnt == glitch_at) begin
            start = 1'b1; vec_len = LW'(1); cmp_op = ~op;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         cnt++;
      end
      start = 1'b0;
      chk(cnt == e_proc + 2, (glitch_at != 0) ? "R11" : "R8", "done latency", cnt, e_proc + 2);
      chk(res_mask == e_mask, (rp ? (zer ? "R3" : "R1/R4") : "R7"), "res_mask", res_mask, e_mask);
      chk(branch_taken == e_taken, (rp && rinv) ? "R6" : "R5", "branch_taken", branch_taken, e_taken);
      chk(trunc_len == LW'(e_trunc), ff ? "R9" : "R8", "trunc_len", trunc_len, e_trunc);
      hold_mask = res_mask; hold_taken = branch_taken; hold_trunc = trunc_len;
      @(negedge clk);
      chk(done == 1'b0, "R10", "done pulse width", done, 0);
      chk(res_mask == hold_mask && branch_taken == hold_taken && trunc_len == hold_trunc,
          "R10", "outputs held", {res_mask, 7'd0, branch_taken}, {hold_mask, 7'd0, hold_taken});
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         n_checks++;
         n_fail++;
         $display("FAIL watchdog timeout actual=%0d expected=<150000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < ML; i++) begin a_arr[i] = '0; b_arr[i] = '0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state (R10)
      chk(done == 0 && busy == 0, "R10", "reset done/busy", {done, busy}, 0);
      chk(res_mask == 0 && branch_taken == 0 && trunc_len == 0, "R10", "reset outputs",
          {res_mask, branch_taken}, 0);

      // R1: exhaustive relations over all operand pairs, all elements active
      for (int op = 0; op < 8; op++) begin
         for (int base = 0; base < 256; base += ML) begin
            for (int i = 0; i < ML; i++) begin
               a_arr[i] = EW'((base + i) >> 4);
               b_arr[i] = EW'(base + i);
            end
            run_vec(ML, 3'(op), 8'hFF, 0, 0, 0, 1, 0, 8'h00, 0);
         end
      end

      // R10: zero length
      run_vec(0, 3'd0, 8'hFF, 0, 0, 0, 1, 0, 8'hA5, 0);
      // R5: all equal, taken
      for (int i = 0; i < ML; i++) begin a_arr[i] = 4'd3; b_arr[i] = 4'd3; end
      run_vec(ML, 3'd0, 8'hFF, 0, 0, 0, 1, 0, 8'h00, 0);
      // R6: all differ, inverted, taken
      run_vec(ML, 3'd1, 8'hFF, 0, 0, 0, 1, 1, 8'h00, 0);
      // R7: no result mask, inversion ignored
      run_vec(ML, 3'd1, 8'h0F, 1, 1, 0, 0, 1, 8'h5A, 0);
      // R2/R4: inverted mask, non-zeroing keeps prior bits
      run_vec(ML, 3'd0, 8'hF0, 1, 0, 0, 1, 0, 8'hFF, 0);
      // R8: over-long length clamped
      run_vec(12, 3'd0, 8'hFF, 0, 0, 0, 1, 0, 8'h00, 0);
      // R11: start during a run ignored
      run_vec(ML, 3'd5, 8'hFF, 0, 0, 0, 1, 0, 8'h00, 3);

      // R2..R9: pseudo-random mixes
      for (int t = 0; t < 500; t++) begin
         logic [31:0] r;
         for (int i = 0; i < ML; i++) begin
            a_arr[i] = EW'(nxt() % 3);
            b_arr[i] = EW'(nxt() % 3);
         end
         r = nxt();
         run_vec(int'(r[3:0] % 9), 3'(r[6:4] % 6), 8'(nxt()), r[7], r[8], r[9],
                 (r[12:10] != 0), r[13], 8'(nxt()), 0);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

endmodule